// File: doc/BRIEF.md
# Integer Arithmetic-Logic Unit with Barrel Shifter

This block is the combinational execute stage of a small 32-bit integer datapath. Each cycle it takes two register operands, an optional 12-bit immediate and a 4-bit operation code, and it returns one 32-bit result in the same cycle. It covers two's complement add and subtract, the three bitwise operations, three shifts and signed or unsigned set-less-than.

When `use_imm` is high, the second operand is not `opnd_b`. It is `imm12` sign-extended to the full word. Every operation can therefore take an immediate. Because the immediate is signed, adding a negative constant does the work of a subtract-immediate. Shifts read the amount from the low five bits of the selected second operand, as an unsigned number, and ignore the upper bits.

Top module: `int_alu`

## Requirements
- R1: With op 0 (add) the result is A + B modulo 2^32. With op 1 (subtract) it is A - B modulo 2^32.
- R2: When `use_imm` is 1, the second operand is `imm12` with bit 11 copied into bits 31..12. When `use_imm` is 0, the second operand is `opnd_b`. The value 0xFFD therefore acts as -3.
- R3: Op 2 gives A AND B, op 3 gives A OR B and op 4 gives A XOR B. Each works on the register form and on the immediate form of B.
- R4: Op 5 shifts A left and fills the vacated low bits with zeros. For example, 0xFFFFFF00 shifted left by 3 gives 0xFFFFF800.
- R5: Op 6 shifts A right and fills with zeros. Op 7 shifts A right and fills with copies of bit 31. For example, 0xFFFFFF00 shifted right by 8 gives 0x00FFFFFF with op 6 and 0xFFFFFFFF with op 7.
- R6: The shift amount is bits 4..0 of the second operand, read as unsigned. All higher bits are ignored. An amount of 0xFFFFFFEA shifts by 10, so 0xFFFFFF00 shifted left by that amount gives 0xFFFC0000.
- R7: Op 8 returns 1 when A < B as signed numbers and returns 0 otherwise. Bits 31..1 of the result are always zero.
- R8: Op 9 returns 1 when A < B as unsigned numbers and returns 0 otherwise.
- R9: Op codes 10 through 15 return zero for any operands.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_sel | input | 4 | Operation code (0 add, 1 sub, 2 and, 3 or, 4 xor, 5 sll, 6 srl, 7 sra, 8 slt, 9 sltu) |
| opnd_a | input | 32 | First operand |
| opnd_b | input | 32 | Second operand, register form |
| imm12 | input | 12 | Signed immediate, used as the second operand when selected |
| use_imm | input | 1 | Selects the sign-extended immediate as the second operand |
| result | output | 32 | Operation result |

## Verification
Each operation is driven with fixed values chosen so that a wrong fill bit, a wrong shift direction or a stray upper shift-amount bit each give a different result. The operand values 0, 1, 0x7FFFFFFF, 0x80000000 and 0xFFFFFFFF set signed order against unsigned order and expose carry and overflow wrap in add and subtract. Random operands mixed with these corner values run through every op code in both the register form and the immediate form. Both immediate polarities are included, so a zero-extension fault shows up. The unused codes are driven with nonzero operands, so any leaked result is visible.

// File: rtl/alu_pkg.sv
package alu_pkg;
   typedef enum logic [3:0] {
      OP_ADD  = 4'd0,
      OP_SUB  = 4'd1,
      OP_AND  = 4'd2,
      OP_OR   = 4'd3,
      OP_XOR  = 4'd4,
      OP_SLL  = 4'd5,
      OP_SRL  = 4'd6,
      OP_SRA  = 4'd7,
      OP_SLT  = 4'd8,
      OP_SLTU = 4'd9
   } alu_op_e;
endpackage

// File: rtl/alu_operand_sel.sv
module alu_operand_sel #(
   parameter int XLEN  = 32,
   parameter int IMM_W = 12
) (
   input  logic [XLEN-1:0]  reg_b,
   input  logic [IMM_W-1:0] imm,
   input  logic             pick_imm,
   output logic [XLEN-1:0]  opnd_out
);
   localparam int PAD_W = XLEN - IMM_W;
   logic [XLEN-1:0] imm_wide;

   generate
      if (PAD_W > 0) begin : g_pad
         assign imm_wide = {{PAD_W{imm[IMM_W-1]}}, imm};
      end else begin : g_nopad
         assign imm_wide = imm;
      end
   endgenerate

   assign opnd_out = pick_imm ? imm_wide : reg_b;
endmodule

// File: rtl/alu_addsub.sv
module alu_addsub #(
   parameter int XLEN = 32
) (
   input  logic [XLEN-1:0] a,
   input  logic [XLEN-1:0] b,
   input  logic            do_sub,
   output logic [XLEN-1:0] sum,
   output logic            lt_signed,
   output logic            lt_unsigned
);
   logic [XLEN:0]   wide;
   logic [XLEN-1:0] b_x;

   assign b_x  = b ^ {XLEN{do_sub}};
   assign wide = {1'b0, a} + {1'b0, b_x} + {{XLEN{1'b0}}, do_sub};
   assign sum  = wide[XLEN-1:0];

   // valid only while do_sub is asserted
   assign lt_unsigned = ~wide[XLEN];
   assign lt_signed   = (a[XLEN-1] != b[XLEN-1]) ? a[XLEN-1] : wide[XLEN-1];
endmodule

// File: rtl/alu_shifter.sv
module alu_shifter #(
   parameter int XLEN = 32,
   parameter int SHW  = 5
) (
   input  logic [XLEN-1:0] din,
   input  logic [SHW-1:0]  amt,
   input  logic            go_left,
   input  logic            arith,
   output logic [XLEN-1:0] dout
);
   logic [XLEN-1:0] flip_in;
   logic [XLEN-1:0] flip_out;
   logic [XLEN-1:0] stage [0:SHW];
   logic            fill;

   genvar i;
   generate
      for (i = 0; i < XLEN; i++) begin : g_rev
         assign flip_in[i]  = din[XLEN-1-i];
         assign flip_out[i] = stage[SHW][XLEN-1-i];
      end
   endgenerate

   assign fill     = arith & ~go_left & din[XLEN-1];
   assign stage[0] = go_left ? flip_in : din;

   genvar s;
   generate
      for (s = 0; s < SHW; s++) begin : g_stage
         localparam int STEP = 1 << s;
         assign stage[s+1] = amt[s] ? {{STEP{fill}}, stage[s][XLEN-1:STEP]} : stage[s];
      end
   endgenerate

   assign dout = go_left ? flip_out : stage[SHW];
endmodule

// File: rtl/int_alu.sv
module int_alu #(
   parameter int XLEN  = 32,
   parameter int IMM_W = 12
) (
   input  logic [3:0]       op_sel,
   input  logic [XLEN-1:0]  opnd_a,
   input  logic [XLEN-1:0]  opnd_b,
   input  logic [IMM_W-1:0] imm12,
   input  logic             use_imm,
   output logic [XLEN-1:0]  result
);
   import alu_pkg::*;
   localparam int SHW = $clog2(XLEN);

   generate
      if ((XLEN & (XLEN - 1)) != 0) begin : g_bad_xlen
         $error("XLEN must be a power of two");
      end
      if (IMM_W > XLEN || IMM_W < 1) begin : g_bad_imm
         $error("IMM_W must lie in 1..XLEN");
      end
   endgenerate

   logic [XLEN-1:0] b_eff, sum, shout;
   logic            lts, ltu, do_sub;
   alu_op_e         op;

   assign op     = alu_op_e'(op_sel);
   assign do_sub = (op == OP_SUB) || (op == OP_SLT) || (op == OP_SLTU);

   alu_operand_sel #(.XLEN(XLEN), .IMM_W(IMM_W)) u_opsel (
      .reg_b(opnd_b), .imm(imm12), .pick_imm(use_imm), .opnd_out(b_eff));

   alu_addsub #(.XLEN(XLEN)) u_addsub (
      .a(opnd_a), .b(b_eff), .do_sub(do_sub), .sum(sum),
      .lt_signed(lts), .lt_unsigned(ltu));

   alu_shifter #(.XLEN(XLEN), .SHW(SHW)) u_shift (
      .din(opnd_a), .amt(b_eff[SHW-1:0]), .go_left(op == OP_SLL),
      .arith(op == OP_SRA), .dout(shout));

   always_comb begin
      case (op_sel)
         OP_ADD, OP_SUB:          result = sum;
         OP_AND:                  result = opnd_a & b_eff;
         OP_OR:                   result = opnd_a | b_eff;
         OP_XOR:                  result = opnd_a ^ b_eff;
         OP_SLL, OP_SRL, OP_SRA:  result = shout;
         OP_SLT:                  result = {{(XLEN-1){1'b0}}, lts};
         OP_SLTU:                 result = {{(XLEN-1){1'b0}}, ltu};
         default:                 result = '0;
      endcase
   end
endmodule

// File: rtl/int_alu_checker.sv
module int_alu_checker #(
   parameter int XLEN  = 32,
   parameter int IMM_W = 12
) (
   input logic [3:0]       op_sel,
   input logic [XLEN-1:0]  opnd_a,
   input logic [XLEN-1:0]  opnd_b,
   input logic [IMM_W-1:0] imm12,
   input logic             use_imm,
   input logic [XLEN-1:0]  result
);
   localparam int SHW = $clog2(XLEN);
   logic [XLEN-1:0] b_seen;
   logic [XLEN-1:0] low_mask;
   logic            known;

   always_comb begin
      b_seen   = use_imm ? XLEN'($signed(imm12)) : opnd_b;
      low_mask = (XLEN'(1) << b_seen[SHW-1:0]) - XLEN'(1);
      known    = !$isunknown({op_sel, opnd_a, opnd_b, imm12, use_imm, result});
      if (known) begin
         // R1
         sub_inverse_chk: assert (op_sel != 4'd1 || result + b_seen == opnd_a)
            else $error("subtract result does not invert");
         // R4
         sll_zero_fill_chk: assert (op_sel != 4'd5 || (result & low_mask) == '0)
            else $error("left shift low bits not zero");
         // R5
         sra_sign_keep_chk: assert (op_sel != 4'd7 || result[XLEN-1] == opnd_a[XLEN-1])
            else $error("arithmetic shift lost sign");
         // R7
         slt_bool_chk: assert (op_sel != 4'd8 || result[XLEN-1:1] == '0)
            else $error("set-less-than not boolean");
         // R9
         unused_zero_chk: assert (op_sel < 4'd10 || result == '0)
            else $error("unused op gave nonzero");
      end
   end
endmodule

bind int_alu int_alu_checker #(.XLEN(XLEN), .IMM_W(IMM_W)) u_chk (
   .op_sel(op_sel), .opnd_a(opnd_a), .opnd_b(opnd_b),
   .imm12(imm12), .use_imm(use_imm), .result(result));

// File: tb/int_alu_test.sv
module int_alu_test;
   typedef struct {
      logic [31:0] exp;
      string       tag;
      logic [3:0]  op;
      logic [31:0] a;
      logic [31:0] b;
   } item_t;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [3:0]  op_sel = 4'd0;
   logic [31:0] opnd_a = '0, opnd_b = '0;
   logic [11:0] imm12 = '0;
   logic        use_imm = 1'b0;
   logic [31:0] result;
   item_t       sb_q[$];
   int          n_run = 0, n_fail = 0;
   bit          driver_done = 0;

   always #10 clk = ~clk;   // 50 MHz

   int_alu uut (.op_sel(op_sel), .opnd_a(opnd_a), .opnd_b(opnd_b),
                .imm12(imm12), .use_imm(use_imm), .result(result));

   function automatic logic [31:0] ref_model(input logic [3:0] op, input logic [31:0] a,
                                             input logic [31:0] b);
      logic [4:0] sh = b[4:0];
      case (op)
         4'd0: return a + b;
         4'd1: return a - b;
         4'd2: return a & b;
         4'd3: return a | b;
         4'd4: return a ^ b;
         4'd5: return a << sh;
         4'd6: return a >> sh;
         4'd7: return $unsigned($signed(a) >>> sh);
         4'd8: return {31'd0, $signed(a) < $signed(b)};
         4'd9: return {31'd0, a < b};
         default: return 32'd0;
      endcase
   endfunction

   function automatic string tag_of(input logic [3:0] op);
      case (op)
         4'd0, 4'd1: return "R1";
         4'd2, 4'd3, 4'd4: return "R3";
         4'd5: return "R4";
         4'd6, 4'd7: return "R5";
         4'd8: return "R7";
         4'd9: return "R8";
         default: return "R9";
      endcase
   endfunction

   task automatic drive(input logic [3:0] op, input logic [31:0] a, input logic [31:0] b,
                        input logic [11:0] imm, input logic ui, input logic [31:0] exp,
                        input string tag);
      item_t it;
      @(posedge clk);
      #1;
      op_sel = op; opnd_a = a; opnd_b = b; imm12 = imm; use_imm = ui;
      it.exp = exp; it.tag = tag; it.op = op; it.a = a; it.b = ui ? {{20{imm[11]}}, imm} : b;
      sb_q.push_back(it);
   endtask

   always @(negedge clk) begin
      if (sb_q.size() > 0) begin
         item_t it;
         it = sb_q.pop_front();
         n_run++;
         if (result !== it.exp) begin
            n_fail++;
            $display("FAIL %s op=%0d a=%h b=%h actual=%h expected=%h",
                     it.tag, it.op, it.a, it.b, result, it.exp);
         end
      end
   end

   initial begin
      int cyc = 0;
      while (!driver_done) begin
         @(posedge clk);
         cyc++;
         if (cyc > 100000) begin
            n_fail++;
            n_run++;
            $display("FAIL watchdog expired");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
         end
      end
   end

   initial begin
      logic [31:0] corners [5] = '{32'h0, 32'h1, 32'h7FFFFFFF, 32'h80000000, 32'hFFFFFFFF};
      repeat (3) @(posedge clk);
      rst_n = 1'b1;
      // idle state: add of zeros (R1)
      drive(4'd0, 32'h0, 32'h0, 12'h0, 1'b0, 32'h0, "R1");
      drive(4'd0, 32'hFFFFFFFF, 32'h1, 12'h0, 1'b0, 32'h0, "R1");
      drive(4'd1, 32'h80000000, 32'h1, 12'h0, 1'b0, 32'h7FFFFFFF, "R1");
      // R2 immediate sign extension
      drive(4'd0, 32'd5, 32'hDEAD0000, 12'hFFD, 1'b1, 32'd2, "R2");
      drive(4'd0, 32'd5, 32'h0, 12'h7FF, 1'b1, 32'd2052, "R2");
      drive(4'd2, 32'h12345678, 32'h0, 12'h800, 1'b1, 32'h12345000, "R2");
      // R3
      drive(4'd3, 32'hF0F00000, 32'h0000FFFF, 12'h0, 1'b0, 32'hF0F0FFFF, "R3");
      drive(4'd4, 32'hAAAA5555, 32'h0, 12'hFFF, 1'b1, 32'h5555AAAA, "R3");
      // R4 / R5
      drive(4'd5, 32'hFFFFFF00, 32'd3, 12'h0, 1'b0, 32'hFFFFF800, "R4");
      drive(4'd6, 32'hFFFFFF00, 32'd8, 12'h0, 1'b0, 32'h00FFFFFF, "R5");
      drive(4'd7, 32'hFFFFFF00, 32'd8, 12'h0, 1'b0, 32'hFFFFFFFF, "R5");
      drive(4'd7, 32'h7FFFFF00, 32'd4, 12'h0, 1'b0, 32'h07FFFFF0, "R5");
      // R6 only low five bits of the amount count
      drive(4'd5, 32'hFFFFFF00, 32'hFFFFFFEA, 12'h0, 1'b0, 32'hFFFC0000, "R6");
      drive(4'd6, 32'h80000000, 32'h00000020, 12'h0, 1'b0, 32'h80000000, "R6");
      drive(4'd7, 32'h80000000, 32'h0, 12'hFFF, 1'b1, 32'hFFFFFFFF, "R6");
      // R7 / R8
      drive(4'd8, 32'hFFFFFFFF, 32'h1, 12'h0, 1'b0, 32'd1, "R7");
      drive(4'd8, 32'h7FFFFFFF, 32'h80000000, 12'h0, 1'b0, 32'd0, "R7");
      drive(4'd8, 32'h5, 32'h0, 12'hFFF, 1'b1, 32'd0, "R7");
      drive(4'd9, 32'hFFFFFFFF, 32'h1, 12'h0, 1'b0, 32'd0, "R8");
      drive(4'd9, 32'h1, 32'h0, 12'hFFF, 1'b1, 32'd1, "R8");
      drive(4'd9, 32'h7, 32'h7, 12'h0, 1'b0, 32'd0, "R8");
      // R9 unused codes
      for (int c = 10; c < 16; c++)
         drive(4'(c), 32'hFFFFFFFF, 32'h12345678, 12'h0, 1'b0, 32'd0, "R9");
      // sweep: corners and random, both operand forms
      for (int op = 0; op < 16; op++) begin
         for (int k = 0; k < 60; k++) begin
            logic [31:0] a, b;
            logic [11:0] im;
            logic        ui;
            a  = (k % 3 == 0) ? corners[k % 5] : $urandom;
            b  = (k % 4 == 1) ? corners[(k / 4) % 5] : $urandom;
            im = 12'($urandom);
            ui = k[0];
            drive(4'(op), a, b, im, ui,
                  ref_model(4'(op), a, ui ? {{20{im[11]}}, im} : b),
                  ui ? "R2" : tag_of(4'(op)));
         end
      end
      @(posedge clk);
      @(posedge clk);
      driver_done = 1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end
endmodule